// File: doc/BRIEF.md
# Host-Slave Mailbox and Interrupt Unit

This block is a small register bank that sits between a card-side controller and a host link. One port carries simple byte reads and writes coming from the host. It stands in for the byte accesses a card function receives over the link. The other port is a 32-bit local bus used by the on-chip processor. Both sides see the same 64 general-purpose mailbox bytes. Byte positions 24 to 27 are a reserved hole with no storage behind them.

Two interrupt paths run through the block.

- **Inbound path:** the host writes a mask to a trigger location. Each 1 bit sets a bit in the inbound status word. The local side reads that word and clears it in a single access, so an event is never both returned and kept.
- **Outbound path:** the local side raises and drops outbound interrupt bits with separate set-mask and clear-mask writes. The host acknowledges bits with write-1-to-clear. A per-bit enable mask gates the active-low interrupt line toward the host.

Top module: `mbox_irq_unit`

## Requirements
- R1: After reset, all mailbox bytes, the inbound status, the outbound status and the enable mask are zero. `host_int_no` is high and both read-data outputs are zero.
- R2: A host write to byte address 0..63 (outside the hole) stores the byte. A host read returns it on `host_rdata_o` in the cycle after the request.
- R3: On the local bus, mailbox word k (addresses 0..15) maps byte 4k+j to bits [8j+7:8j]. A write updates only the bytes whose `loc_be_i[j]` is set. A read returns the word in the cycle after the request.
- R4: Byte positions 24..27 (local word 6) always read as zero. Host or local writes to them change no mailbox byte.
- R5: When the host and the local side write the same byte in the same cycle, the host data is stored. The other enabled bytes of the local word still take the local data.
- R6: A host write to address 64 ORs `host_wdata_i` into the inbound status. Bits written as 0 are left unchanged.
- R7: A local read of word 16 returns the inbound status and clears it. A bit set by the host in that same cycle is not returned and remains pending.
- R8: A local write to word 17 sets the outbound status bits given by `loc_wdata_i[7:0]`. A write to word 18 clears them. All other bits are kept. A local read of word 20 returns the outbound status.
- R9: A host read of address 65 returns the outbound status. A host write to address 65 clears the bits written as 1. If a local set of the same bit falls in the same cycle, the set wins.
- R10: Local word 19 reads and writes the outbound enable mask. `host_int_no` is low exactly when some outbound status bit and its enable bit are both 1. It follows the register state from the cycle after the write that changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Host access strobe |
| host_we_i | input | 1 | Host access is a write |
| host_addr_i | input | 7 | Host byte address |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data, registered |
| loc_req_i | input | 1 | Local access strobe |
| loc_we_i | input | 1 | Local access is a write |
| loc_addr_i | input | 5 | Local word address |
| loc_be_i | input | 4 | Local byte enables (mailbox words only) |
| loc_wdata_i | input | 32 | Local write data |
| loc_rdata_o | output | 32 | Local read data, registered |
| host_int_no | output | 1 | Interrupt to host, active low |

## Verification
Several pairs of functions can land in the same clock edge:

- **Mailbox writes:** a host byte write and a local word write to the same mailbox word.
- **Inbound status:** a host trigger write and the local fetch-and-clear of the inbound word.
- **Outbound status:** a host acknowledge and a local set of the same outbound bit.

The bench drives both ports in one cycle for each of these pairs and judges the outcome only from later reads. It checks three things. The colliding byte holds the host value while its neighbours hold local data. The fetch returns only the older bits, while the fresh bit shows up in the next fetch. The outbound bit that was set and acknowledged in one cycle stays set.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // offsets of control locations past the mailbox, host side (bytes)
  localparam int HOST_OFS_TRIG = 0;
  localparam int HOST_OFS_STAT = 1;
  // offsets of control locations past the mailbox, local side (words)
  localparam int LOC_OFS_FETCH = 0;
  localparam int LOC_OFS_SET   = 1;
  localparam int LOC_OFS_CLR   = 2;
  localparam int LOC_OFS_EN    = 3;
  localparam int LOC_OFS_STAT  = 4;
endpackage

// File: rtl/mbox_bank.sv
module mbox_bank #(
  parameter int NUM_BYTES = 64,
  parameter int HOLE_LO   = 24,
  parameter int HOLE_HI   = 27,
  localparam int NUM_WORDS = NUM_BYTES / 4,
  localparam int IDX_W     = $clog2(NUM_BYTES),
  localparam int WIDX_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              h_we_i,
  input  logic [IDX_W-1:0]  h_idx_i,
  input  logic [7:0]        h_wdata_i,
  input  logic              l_we_i,
  input  logic [WIDX_W-1:0] l_word_i,
  input  logic [3:0]        l_be_i,
  input  logic [31:0]       l_wdata_i,
  output logic [7:0]        h_rbyte_o,
  output logic [31:0]       l_rword_o
);
  logic [7:0]  byte_w [NUM_BYTES];
  logic [31:0] word_w [NUM_WORDS];

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    if (b >= HOLE_LO && b <= HOLE_HI) begin : g_hole
      assign byte_w[b] = 8'h00;
    end else begin : g_reg
      logic [7:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 8'h00;
        else if (h_we_i && h_idx_i == IDX_W'(b)) q <= h_wdata_i;  // host has priority
        else if (l_we_i && l_word_i == WIDX_W'(b / 4) && l_be_i[b % 4])
          q <= l_wdata_i[8*(b%4) +: 8];
      end
      assign byte_w[b] = q;
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign word_w[w] = {byte_w[4*w+3], byte_w[4*w+2], byte_w[4*w+1], byte_w[4*w]};
  end

  assign h_rbyte_o = byte_w[h_idx_i];
  assign l_rword_o = word_w[l_word_i];
endmodule

// File: rtl/mbox_slv_irq.sv
module mbox_slv_irq #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic [W-1:0] set_mask_i,
  input  logic         fetch_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;

  // fetch clears what was pending; a same-cycle set survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else stat_q <= (fetch_i ? '0 : stat_q) | (set_i ? set_mask_i : '0);
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/mbox_host_irq.sv
module mbox_host_irq #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] mask_i,
  input  logic         hclr_i,
  input  logic [W-1:0] hclr_mask_i,
  input  logic         en_we_i,
  input  logic [W-1:0] en_wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] en_o,
  output logic         irq_no
);
  logic [W-1:0] stat_q, en_q, drop;

  assign drop = (clr_i ? mask_i : '0) | (hclr_i ? hclr_mask_i : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= (stat_q & ~drop) | (set_i ? mask_i : '0);  // set wins over clear
      if (en_we_i) en_q <= en_wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign irq_no = ~|(stat_q & en_q);
endmodule

// File: rtl/mbox_irq_unit.sv
module mbox_irq_unit
  import mbox_pkg::*;
#(
  parameter int NUM_BYTES  = 64,
  parameter int HOLE_LO    = 24,
  parameter int HOLE_HI    = 27,
  parameter int SLV_INT_W  = 8,
  parameter int HOST_INT_W = 8,
  localparam int NUM_WORDS = NUM_BYTES / 4,
  localparam int IDX_W     = $clog2(NUM_BYTES),
  localparam int WIDX_W    = $clog2(NUM_WORDS),
  localparam int HADDR_W   = IDX_W + 1,
  localparam int LADDR_W   = WIDX_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_req_i,
  input  logic               host_we_i,
  input  logic [HADDR_W-1:0] host_addr_i,
  input  logic [7:0]         host_wdata_i,
  output logic [7:0]         host_rdata_o,
  input  logic               loc_req_i,
  input  logic               loc_we_i,
  input  logic [LADDR_W-1:0] loc_addr_i,
  input  logic [3:0]         loc_be_i,
  input  logic [31:0]        loc_wdata_i,
  output logic [31:0]        loc_rdata_o,
  output logic               host_int_no
);
  localparam logic [HADDR_W-1:0] H_BANK_END = HADDR_W'(NUM_BYTES);
  localparam logic [HADDR_W-1:0] H_TRIG     = HADDR_W'(NUM_BYTES + HOST_OFS_TRIG);
  localparam logic [HADDR_W-1:0] H_STAT     = HADDR_W'(NUM_BYTES + HOST_OFS_STAT);
  localparam logic [LADDR_W-1:0] L_BANK_END = LADDR_W'(NUM_WORDS);
  localparam logic [LADDR_W-1:0] L_FETCH    = LADDR_W'(NUM_WORDS + LOC_OFS_FETCH);
  localparam logic [LADDR_W-1:0] L_SET      = LADDR_W'(NUM_WORDS + LOC_OFS_SET);
  localparam logic [LADDR_W-1:0] L_CLR      = LADDR_W'(NUM_WORDS + LOC_OFS_CLR);
  localparam logic [LADDR_W-1:0] L_EN       = LADDR_W'(NUM_WORDS + LOC_OFS_EN);
  localparam logic [LADDR_W-1:0] L_STAT     = LADDR_W'(NUM_WORDS + LOC_OFS_STAT);

  logic                  h_bank, l_bank;
  logic [7:0]            h_rbyte;
  logic [31:0]           l_rword;
  logic [SLV_INT_W-1:0]  slv_stat;
  logic [HOST_INT_W-1:0] host_stat, host_en;
  logic                  l_fetch;
  logic [7:0]            host_rdata_q;
  logic [31:0]           loc_rdata_q;

  assign h_bank  = host_addr_i < H_BANK_END;
  assign l_bank  = loc_addr_i < L_BANK_END;
  assign l_fetch = loc_req_i && !loc_we_i && loc_addr_i == L_FETCH;

  mbox_bank #(.NUM_BYTES(NUM_BYTES), .HOLE_LO(HOLE_LO), .HOLE_HI(HOLE_HI)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .h_we_i    (host_req_i && host_we_i && h_bank),
    .h_idx_i   (host_addr_i[IDX_W-1:0]),
    .h_wdata_i (host_wdata_i),
    .l_we_i    (loc_req_i && loc_we_i && l_bank),
    .l_word_i  (loc_addr_i[WIDX_W-1:0]),
    .l_be_i    (loc_be_i),
    .l_wdata_i (loc_wdata_i),
    .h_rbyte_o (h_rbyte),
    .l_rword_o (l_rword)
  );

  mbox_slv_irq #(.W(SLV_INT_W)) u_slv_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (host_req_i && host_we_i && host_addr_i == H_TRIG),
    .set_mask_i (host_wdata_i[SLV_INT_W-1:0]),
    .fetch_i    (l_fetch),
    .stat_o     (slv_stat)
  );

  mbox_host_irq #(.W(HOST_INT_W)) u_host_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (loc_req_i && loc_we_i && loc_addr_i == L_SET),
    .clr_i       (loc_req_i && loc_we_i && loc_addr_i == L_CLR),
    .mask_i      (loc_wdata_i[HOST_INT_W-1:0]),
    .hclr_i      (host_req_i && host_we_i && host_addr_i == H_STAT),
    .hclr_mask_i (host_wdata_i[HOST_INT_W-1:0]),
    .en_we_i     (loc_req_i && loc_we_i && loc_addr_i == L_EN),
    .en_wdata_i  (loc_wdata_i[HOST_INT_W-1:0]),
    .stat_o      (host_stat),
    .en_o        (host_en),
    .irq_no      (host_int_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_rdata_q <= '0;
      loc_rdata_q  <= '0;
    end else begin
      if (host_req_i && !host_we_i) begin
        if (h_bank)                    host_rdata_q <= h_rbyte;
        else if (host_addr_i == H_STAT) host_rdata_q <= 8'(host_stat);
        else                           host_rdata_q <= '0;
      end
      if (loc_req_i && !loc_we_i) begin
        if (l_bank)                   loc_rdata_q <= l_rword;
        else if (l_fetch)             loc_rdata_q <= 32'(slv_stat);
        else if (loc_addr_i == L_EN)   loc_rdata_q <= 32'(host_en);
        else if (loc_addr_i == L_STAT) loc_rdata_q <= 32'(host_stat);
        else                          loc_rdata_q <= '0;
      end
    end
  end

  assign host_rdata_o = host_rdata_q;
  assign loc_rdata_o  = loc_rdata_q;
endmodule

// File: rtl/mbox_irq_unit_chk.sv
module mbox_irq_unit_chk
  import mbox_pkg::*;
#(
  parameter int NUM_BYTES  = 64,
  parameter int HOLE_LO    = 24,
  parameter int HOLE_HI    = 27,
  parameter int SLV_INT_W  = 8,
  parameter int HOST_INT_W = 8,
  localparam int NUM_WORDS = NUM_BYTES / 4,
  localparam int HADDR_W   = $clog2(NUM_BYTES) + 1,
  localparam int LADDR_W   = $clog2(NUM_WORDS) + 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  host_req_i,
  input logic                  host_we_i,
  input logic [HADDR_W-1:0]    host_addr_i,
  input logic [7:0]            host_wdata_i,
  input logic [7:0]            host_rdata_o,
  input logic                  loc_req_i,
  input logic                  loc_we_i,
  input logic [LADDR_W-1:0]    loc_addr_i,
  input logic [31:0]           loc_wdata_i,
  input logic                  host_int_no,
  input logic [SLV_INT_W-1:0]  slv_stat,
  input logic [HOST_INT_W-1:0] host_stat,
  input logic [HOST_INT_W-1:0] host_en
);
  localparam logic [HADDR_W-1:0] H_LO   = HADDR_W'(HOLE_LO);
  localparam logic [HADDR_W-1:0] H_HI   = HADDR_W'(HOLE_HI);
  localparam logic [HADDR_W-1:0] H_TRIG = HADDR_W'(NUM_BYTES + HOST_OFS_TRIG);
  localparam logic [LADDR_W-1:0] L_FET  = LADDR_W'(NUM_WORDS + LOC_OFS_FETCH);
  localparam logic [LADDR_W-1:0] L_SET  = LADDR_W'(NUM_WORDS + LOC_OFS_SET);
  localparam logic [LADDR_W-1:0] L_CLR  = LADDR_W'(NUM_WORDS + LOC_OFS_CLR);

  logic h_trig, l_fetch, l_set, l_clr;
  assign h_trig  = host_req_i && host_we_i && host_addr_i == H_TRIG;
  assign l_fetch = loc_req_i && !loc_we_i && loc_addr_i == L_FET;
  assign l_set   = loc_req_i && loc_we_i && loc_addr_i == L_SET;
  assign l_clr   = loc_req_i && loc_we_i && loc_addr_i == L_CLR;

  assert_hole_reads_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i && !host_we_i && host_addr_i >= H_LO && host_addr_i <= H_HI |=> host_rdata_o == 8'h00);

  assert_trigger_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_trig |=> (slv_stat & $past(host_wdata_i[SLV_INT_W-1:0])) == $past(host_wdata_i[SLV_INT_W-1:0]));

  assert_fetch_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_fetch && !h_trig |=> slv_stat == '0);

  assert_set_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_set |=> (host_stat & $past(loc_wdata_i[HOST_INT_W-1:0])) == $past(loc_wdata_i[HOST_INT_W-1:0]));

  assert_clr_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_clr |=> (host_stat & $past(loc_wdata_i[HOST_INT_W-1:0])) == '0);

  assert_irq_follows_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_set && (loc_wdata_i[HOST_INT_W-1:0] & host_en) != '0 |=> !host_int_no);
endmodule

bind mbox_irq_unit mbox_irq_unit_chk #(
  .NUM_BYTES(NUM_BYTES), .HOLE_LO(HOLE_LO), .HOLE_HI(HOLE_HI),
  .SLV_INT_W(SLV_INT_W), .HOST_INT_W(HOST_INT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .host_req_i(host_req_i), .host_we_i(host_we_i), .host_addr_i(host_addr_i),
  .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o),
  .loc_req_i(loc_req_i), .loc_we_i(loc_we_i), .loc_addr_i(loc_addr_i),
  .loc_wdata_i(loc_wdata_i), .host_int_no(host_int_no),
  .slv_stat(slv_stat), .host_stat(host_stat), .host_en(host_en)
);

// File: tb/mbox_irq_unit_bench.sv
`timescale 1ns/1ps
module mbox_irq_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_req_i = 1'b0, host_we_i = 1'b0;
  logic [6:0]  host_addr_i = '0;
  logic [7:0]  host_wdata_i = '0;
  logic [7:0]  host_rdata_o;
  logic        loc_req_i = 1'b0, loc_we_i = 1'b0;
  logic [4:0]  loc_addr_i = '0;
  logic [3:0]  loc_be_i = '0;
  logic [31:0] loc_wdata_i = '0;
  logic [31:0] loc_rdata_o;
  logic        host_int_no;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  mbox_irq_unit u_mbox_irq_unit (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    host_req_i = 0; host_we_i = 0; loc_req_i = 0; loc_we_i = 0;
  endtask

  task automatic host_wr(logic [6:0] a, logic [7:0] d);
    host_req_i = 1; host_we_i = 1; host_addr_i = a; host_wdata_i = d;
    @(negedge clk_i); idle();
  endtask

  task automatic host_rd(logic [6:0] a, output logic [7:0] d);
    host_req_i = 1; host_we_i = 0; host_addr_i = a;
    @(negedge clk_i); d = host_rdata_o; idle();
  endtask

  task automatic loc_wr(logic [4:0] a, logic [3:0] be, logic [31:0] d);
    loc_req_i = 1; loc_we_i = 1; loc_addr_i = a; loc_be_i = be; loc_wdata_i = d;
    @(negedge clk_i); idle();
  endtask

  task automatic loc_rd(logic [4:0] a, output logic [31:0] d);
    loc_req_i = 1; loc_we_i = 0; loc_addr_i = a;
    @(negedge clk_i); d = loc_rdata_o; idle();
  endtask

  task automatic t_reset();
    logic [7:0] b; logic [31:0] w;
    check("R1 irq", 32'(host_int_no), 32'd1);
    check("R1 host rdata", 32'(host_rdata_o), 32'd0);
    check("R1 loc rdata", loc_rdata_o, 32'd0);
    host_rd(7'd5, b);   check("R1 byte5", 32'(b), 32'd0);
    loc_rd(5'd19, w);   check("R1 enable", w, 32'd0);
    loc_rd(5'd16, w);   check("R1 inbound", w, 32'd0);
    loc_rd(5'd20, w);   check("R1 outbound", w, 32'd0);
  endtask

  task automatic t_host_bytes();
    logic [7:0] b;
    host_wr(7'd0, 8'h11); host_wr(7'd63, 8'hA5); host_wr(7'd23, 8'h3C); host_wr(7'd28, 8'h77);
    host_rd(7'd0, b);  check("R2 byte0", 32'(b), 32'h11);
    host_rd(7'd63, b); check("R2 byte63", 32'(b), 32'hA5);
    host_rd(7'd23, b); check("R2 byte23", 32'(b), 32'h3C);
    host_rd(7'd28, b); check("R2 byte28", 32'(b), 32'h77);
  endtask

  task automatic t_local_words();
    logic [7:0] b; logic [31:0] w;
    loc_wr(5'd2, 4'b1111, 32'h44332211);
    host_rd(7'd8, b);  check("R3 byte8", 32'(b), 32'h11);
    host_rd(7'd11, b); check("R3 byte11", 32'(b), 32'h44);
    loc_wr(5'd2, 4'b0100, 32'hAABBCCDD);
    loc_rd(5'd2, w);   check("R3 partial be", w, 32'h44BB2211);
    loc_rd(5'd15, w);  check("R3 word15 top", 32'(w[31:24]), 32'hA5);
  endtask

  task automatic t_hole();
    logic [7:0] b; logic [31:0] w;
    host_wr(7'd25, 8'hFF);
    host_rd(7'd25, b); check("R4 host hole", 32'(b), 32'h0);
    loc_wr(5'd6, 4'b1111, 32'hFFFFFFFF);
    loc_rd(5'd6, w);   check("R4 local hole", w, 32'h0);
    loc_rd(5'd5, w);   check("R4 neighbour low", w, 32'h3C000000);
    loc_rd(5'd7, w);   check("R4 neighbour high", w, 32'h00000077);
  endtask

  task automatic t_same_byte();
    logic [31:0] w;
    host_req_i = 1; host_we_i = 1; host_addr_i = 7'd12; host_wdata_i = 8'h5A;
    loc_req_i = 1; loc_we_i = 1; loc_addr_i = 5'd3; loc_be_i = 4'b1111; loc_wdata_i = 32'h01020304;
    @(negedge clk_i); idle();
    loc_rd(5'd3, w); check("R5 host wins", w, 32'h0102035A);
  endtask

  task automatic t_inbound();
    logic [31:0] w;
    host_wr(7'd64, 8'h05);
    loc_rd(5'd16, w); check("R7 fetch", w, 32'h05);
    loc_rd(5'd16, w); check("R7 cleared", w, 32'h00);
    host_wr(7'd64, 8'h01); host_wr(7'd64, 8'h80);
    loc_rd(5'd16, w); check("R6 or-accumulate", w, 32'h81);
    host_wr(7'd64, 8'h02);
    host_req_i = 1; host_we_i = 1; host_addr_i = 7'd64; host_wdata_i = 8'h10;
    loc_req_i = 1; loc_we_i = 0; loc_addr_i = 5'd16;
    @(negedge clk_i); w = loc_rdata_o; idle();
    check("R7 same-cycle fetch", w, 32'h02);
    loc_rd(5'd16, w); check("R7 same-cycle bit kept", w, 32'h10);
  endtask

  task automatic t_outbound();
    logic [31:0] w; logic [7:0] b;
    loc_wr(5'd17, 4'b1111, 32'h0C);
    loc_rd(5'd20, w); check("R8 set", w, 32'h0C);
    check("R10 masked off", 32'(host_int_no), 32'd1);
    loc_wr(5'd19, 4'b1111, 32'h04);
    check("R10 asserted", 32'(host_int_no), 32'd0);
    loc_rd(5'd19, w); check("R10 enable readback", w, 32'h04);
    loc_wr(5'd18, 4'b1111, 32'h04);
    loc_rd(5'd20, w); check("R8 clear", w, 32'h08);
    check("R10 released", 32'(host_int_no), 32'd1);
    loc_wr(5'd19, 4'b1111, 32'h08);
    check("R10 re-enabled", 32'(host_int_no), 32'd0);
    host_rd(7'd65, b); check("R9 host read", 32'(b), 32'h08);
    host_wr(7'd65, 8'h08);
    loc_rd(5'd20, w); check("R9 host clear", w, 32'h00);
    check("R9 irq after ack", 32'(host_int_no), 32'd1);
    host_req_i = 1; host_we_i = 1; host_addr_i = 7'd65; host_wdata_i = 8'h01;
    loc_req_i = 1; loc_we_i = 1; loc_addr_i = 5'd17; loc_wdata_i = 32'h01;
    @(negedge clk_i); idle();
    loc_rd(5'd20, w); check("R9 set beats ack", w, 32'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_host_bytes();
    t_local_words();
    t_hole();
    t_same_byte();
    t_inbound();
    t_outbound();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule